// File: doc/BRIEF.md
# Warp-Grouped Bank Request Selector

This block is the arbitration stage of one DRAM bank in a GPU memory controller. Requests waiting for the bank are kept in a small slot table and grouped by the warp that produced them. A request counter per warp gives the length of each warp's queue. On every issue slot the selector names one request to send to the bank: its slot, its row, the warp and core it belongs to, and whether it hits the open row.

Selection works in two stages. The first stage takes the core with the lowest tolerance value among the cores that have work for the bank. Tolerance is supplied per core from outside, normally ready warps times a fixed work amount. The second stage looks only at that core's warps. It finds the shortest warp queue that holds an open-row hit and the shortest queue that holds none. It then weighs the two with a fixed-point factor k that software loads. Once a hit queue has been chosen, the selector keeps serving it until that queue runs out of hits. Reads normally go before writes; a mode input treats both kinds alike.

Top module: `wsel_top`

## Requirements
- R1: After reset no grant is raised and the open row is marked invalid, so a request to row 0 is not a hit.
- R2: When no eligible request is pending, grantValid is 0.
- R3: Each accepted enqueue adds one request to its warp's queue. Each issue (issueSlot high while grantValid is high) removes exactly the granted request. A warp whose queue is empty is never granted.
- R4: Stage one picks the core with the lowest coreTol among the cores that have eligible requests. Warp w belongs to core w / WARPS_PER_CORE, coreTol holds core c in bits [c*TOL_W +: TOL_W], and equal tolerances go to the lower core index.
- R5: When the chosen core has both a shortest hit queue (length H) and a shortest no-hit queue (length M), the no-hit queue is granted if H*4 > kScale*M. kScale has 2 fraction bits, so 4 means 1.0. Otherwise the hit queue is granted.
- R6: If the core has only hit queues, the shortest hit queue is granted. If it has only no-hit queues, the shortest of those is granted. Equal lengths go to the lower warp index.
- R7: After a request that hit the open row is issued, the same warp is granted again, regardless of tolerance and kScale, for as long as it still holds an eligible hit.
- R8: A request hits only when its row equals the open row and the open row is valid. Issuing a non-hit request loads its row as the open row.
- R9: With writesEqual = 0, writes are eligible only when no read is pending, and queue lengths count only the eligible kind.
- R10: With writesEqual = 1, reads and writes are equally eligible and each queue length counts both kinds.
- R11: Inside the granted warp, the lowest-index eligible hit slot is granted if the warp holds a hit; otherwise its lowest-index eligible slot is granted. An enqueue takes the lowest free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Write a new request into the lowest free slot (ignored when full) |
| enqWarp | input | WARP_W (3) | Warp that issued the new request |
| enqWrite | input | 1 | New request is a write |
| enqRow | input | ROW_W (8) | Row addressed by the new request |
| issueSlot | input | 1 | Issue opportunity this cycle; removes the granted request |
| writesEqual | input | 1 | 1: reads and writes equal; 0: reads first |
| coreTol | input | CORES*TOL_W (16) | Per-core tolerance values |
| kScale | input | K_W (6) | Threshold k, unsigned with 2 fraction bits |
| grantValid | output | 1 | A request is offered |
| grantCore | output | CORE_W (1) | Core of the offered request |
| grantWarp | output | WARP_W (3) | Warp of the offered request |
| grantSlot | output | SLOT_W (3) | Slot index of the offered request |
| grantRow | output | ROW_W (8) | Row of the offered request |
| grantHit | output | 1 | Offered request hits the open row |

## Verification
The bench puts the hit/no-hit comparison exactly on its edge: k = 3.0 against H = 3 and M = 1, then one step below. A design that used >= instead of > flips the choice at that point. It also sets k to zero right after a hit issue. A design without the sticky rule then leaves the hit warp. A stage-one core that has the lowest tolerance but no work must be skipped; a design that did not skip it would stall with no grant. A request to row 0 after reset must not count as a hit. Read-first ordering is checked by a write that only becomes eligible after the last read has gone, and a design that ignored the mode would grant the shorter write queue first.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
  parameter int unsigned CORES          = 2;
  parameter int unsigned WARPS_PER_CORE = 4;
  parameter int unsigned SLOTS          = 8;
  parameter int unsigned ROW_W          = 8;
  parameter int unsigned TOL_W          = 8;
  parameter int unsigned K_INT          = 4;
  parameter int unsigned K_FRAC         = 2;

  localparam int unsigned WARPS  = CORES * WARPS_PER_CORE;
  localparam int unsigned WARP_W = $clog2(WARPS);
  localparam int unsigned CORE_W = $clog2(CORES);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
  localparam int unsigned K_W    = K_INT + K_FRAC;
  localparam int unsigned PROD_W = CNT_W + K_W;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic              fire;
    logic              hit;
    logic [WARP_W-1:0] warp;
    logic [SLOT_W-1:0] slot;
  } issue_t;
endpackage

// File: rtl/wsel_datapath.sv
module wsel_datapath
  import wsel_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enqValid,
  input  logic [WARP_W-1:0]           enqWarp,
  input  logic                        enqWrite,
  input  logic [ROW_W-1:0]            enqRow,
  input  logic                        writesEqual,
  input  issue_t                      cmd,
  output logic [SLOTS-1:0]            slotElig,
  output logic [SLOTS-1:0]            slotHit,
  output logic [SLOTS-1:0]            slotWr,
  output logic [SLOTS-1:0][WARP_W-1:0] slotWarp,
  output logic [SLOTS-1:0][ROW_W-1:0] slotRow,
  output logic [WARPS-1:0][CNT_W-1:0] warpLen,
  output logic [WARPS-1:0]            warpHit,
  output logic                        anyRead,
  output logic                        stickyValid,
  output logic [WARP_W-1:0]           stickyWarp
);
  logic [SLOTS-1:0]            slotValid;
  logic [WARPS-1:0][CNT_W-1:0] rdCnt, wrCnt, rdNext, wrNext;
  logic [ROW_W-1:0]            openRow;
  logic                        openValid;
  logic                        freeFound, enqAccept;
  logic [SLOT_W-1:0]           freeSlot;

  always_comb begin
    freeFound = 1'b0;
    freeSlot  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!slotValid[s]) begin
        freeFound = 1'b1;
        freeSlot  = SLOT_W'(s);
      end
    end
  end
  assign enqAccept = enqValid && freeFound;

  assign anyRead = |(slotValid & ~slotWr);

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : gSlot
      assign slotElig[s] = slotValid[s] && (writesEqual || !anyRead || !slotWr[s]);
      assign slotHit[s]  = slotElig[s] && openValid && (slotRow[s] == openRow);
    end
    for (genvar w = 0; w < WARPS; w++) begin : gWarp
      logic [SLOTS-1:0] ownHit;
      for (genvar s = 0; s < SLOTS; s++) begin : gOwn
        assign ownHit[s] = slotHit[s] && (slotWarp[s] == WARP_W'(w));
      end
      assign warpHit[w] = |ownHit;
      assign warpLen[w] = writesEqual ? CNT_W'(rdCnt[w] + wrCnt[w])
                        : (anyRead ? rdCnt[w] : wrCnt[w]);
    end
  endgenerate

  always_comb begin
    rdNext = rdCnt;
    wrNext = wrCnt;
    if (enqAccept) begin
      if (enqWrite) wrNext[enqWarp] = wrNext[enqWarp] + 1'b1;
      else          rdNext[enqWarp] = rdNext[enqWarp] + 1'b1;
    end
    if (cmd.fire) begin
      if (slotWr[cmd.slot]) wrNext[cmd.warp] = wrNext[cmd.warp] - 1'b1;
      else                  rdNext[cmd.warp] = rdNext[cmd.warp] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid   <= '0;
      slotWr      <= '0;
      slotWarp    <= '0;
      slotRow     <= '0;
      rdCnt       <= '0;
      wrCnt       <= '0;
      openRow     <= '0;
      openValid   <= 1'b0;
      stickyValid <= 1'b0;
      stickyWarp  <= '0;
    end else begin
      rdCnt <= rdNext;
      wrCnt <= wrNext;
      if (cmd.fire) begin
        slotValid[cmd.slot] <= 1'b0;
        stickyValid         <= cmd.hit;
        stickyWarp          <= cmd.warp;
        if (!cmd.hit) begin
          openRow   <= slotRow[cmd.slot];
          openValid <= 1'b1;
        end
      end
      if (enqAccept) begin
        slotValid[freeSlot] <= 1'b1;
        slotWr[freeSlot]    <= enqWrite;
        slotWarp[freeSlot]  <= enqWarp;
        slotRow[freeSlot]   <= enqRow;
      end
    end
  end

  AST_ISSUE_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.fire |-> (warpLen[cmd.warp] != '0)); // R3
  AST_MISS_OPENS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fire && !cmd.hit) |=> (openValid && openRow == $past(slotRow[cmd.slot]))); // R8
endmodule

// File: rtl/wsel_control.sv
module wsel_control
  import wsel_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         issueSlot,
  input  logic                         writesEqual,
  input  logic [CORES*TOL_W-1:0]       coreTol,
  input  logic [K_W-1:0]               kScale,
  input  logic [SLOTS-1:0]             slotElig,
  input  logic [SLOTS-1:0]             slotHit,
  input  logic [SLOTS-1:0]             slotWr,
  input  logic [SLOTS-1:0][WARP_W-1:0] slotWarp,
  input  logic [SLOTS-1:0][ROW_W-1:0]  slotRow,
  input  logic [WARPS-1:0][CNT_W-1:0]  warpLen,
  input  logic [WARPS-1:0]             warpHit,
  input  logic                         anyRead,
  input  logic                         stickyValid,
  input  logic [WARP_W-1:0]            stickyWarp,
  output issue_t                       cmd,
  output logic                         grantValid,
  output logic [CORE_W-1:0]            grantCore,
  output logic [WARP_W-1:0]            grantWarp,
  output logic [SLOT_W-1:0]            grantSlot,
  output logic [ROW_W-1:0]             grantRow,
  output logic                         grantHit
);
  logic [CORES-1:0]  coreBusy;
  logic              coreFound, hFound, mFound, pickMiss, stickyLive;
  logic [CORE_W-1:0] selCore;
  logic [TOL_W-1:0]  bestTol;
  logic [WARP_W-1:0] hWarp, mWarp, selWarp;
  logic [CNT_W-1:0]  hLen, mLen;
  logic [PROD_W-1:0] hScaled, mScaled;
  logic              slotFound;

  generate
    for (genvar c = 0; c < CORES; c++) begin : gCore
      logic [WARPS_PER_CORE-1:0] nz;
      for (genvar j = 0; j < WARPS_PER_CORE; j++) begin : gNz
        assign nz[j] = warpLen[c*WARPS_PER_CORE + j] != '0;
      end
      assign coreBusy[c] = |nz;
    end
  endgenerate

  // stage one: lowest tolerance among cores with work
  always_comb begin
    coreFound = 1'b0;
    selCore   = '0;
    bestTol   = '0;
    for (int c = 0; c < CORES; c++) begin
      if (coreBusy[c] && (!coreFound || coreTol[c*TOL_W +: TOL_W] < bestTol)) begin
        coreFound = 1'b1;
        selCore   = CORE_W'(c);
        bestTol   = coreTol[c*TOL_W +: TOL_W];
      end
    end
  end

  // stage two: shortest hit queue and shortest no-hit queue in that core
  always_comb begin
    hFound = 1'b0; mFound = 1'b0;
    hWarp  = '0;   mWarp  = '0;
    hLen   = '0;   mLen   = '0;
    for (int w = 0; w < WARPS; w++) begin
      if ((w / WARPS_PER_CORE) == int'(selCore) && warpLen[w] != '0) begin
        if (warpHit[w]) begin
          if (!hFound || warpLen[w] < hLen) begin
            hFound = 1'b1; hWarp = WARP_W'(w); hLen = warpLen[w];
          end
        end else if (!mFound || warpLen[w] < mLen) begin
          mFound = 1'b1; mWarp = WARP_W'(w); mLen = warpLen[w];
        end
      end
    end
  end

  assign hScaled    = PROD_W'({hLen, {K_FRAC{1'b0}}});
  assign mScaled    = PROD_W'(kScale) * PROD_W'(mLen);
  assign pickMiss   = !hFound || (mFound && hScaled > mScaled);
  assign stickyLive = stickyValid && warpHit[stickyWarp];
  assign selWarp    = stickyLive ? stickyWarp : (pickMiss ? mWarp : hWarp);
  assign grantHit   = warpHit[selWarp];

  always_comb begin
    slotFound = 1'b0;
    grantSlot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (slotElig[s] && slotWarp[s] == selWarp && (!grantHit || slotHit[s])) begin
        slotFound = 1'b1;
        grantSlot = SLOT_W'(s);
      end
    end
  end

  assign grantValid = coreFound && slotFound;
  assign grantWarp  = selWarp;
  assign grantCore  = CORE_W'(selWarp / WARP_W'(WARPS_PER_CORE));
  assign grantRow   = slotRow[grantSlot];

  assign cmd.fire = issueSlot && grantValid;
  assign cmd.hit  = grantHit;
  assign cmd.warp = grantWarp;
  assign cmd.slot = grantSlot;

  AST_NO_GRANT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (slotElig == '0) |-> !grantValid); // R2
  AST_READS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !writesEqual && anyRead) |-> !slotWr[grantSlot]); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fire && cmd.hit) |=> (!warpHit[$past(cmd.warp)] || (grantValid && grantWarp == $past(cmd.warp)))); // R7
  AST_GRANT_OWN_WARP: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (slotElig[grantSlot] && slotWarp[grantSlot] == grantWarp)); // R11
endmodule

// File: rtl/wsel_top.sv
module wsel_top
  import wsel_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enqValid,
  input  logic [WARP_W-1:0]      enqWarp,
  input  logic                   enqWrite,
  input  logic [ROW_W-1:0]       enqRow,
  input  logic                   issueSlot,
  input  logic                   writesEqual,
  input  logic [CORES*TOL_W-1:0] coreTol,
  input  logic [K_W-1:0]         kScale,
  output logic                   grantValid,
  output logic [CORE_W-1:0]      grantCore,
  output logic [WARP_W-1:0]      grantWarp,
  output logic [SLOT_W-1:0]      grantSlot,
  output logic [ROW_W-1:0]       grantRow,
  output logic                   grantHit
);
  issue_t                      cmd;
  logic [SLOTS-1:0]            slotElig, slotHit, slotWr;
  logic [SLOTS-1:0][WARP_W-1:0] slotWarp;
  logic [SLOTS-1:0][ROW_W-1:0] slotRow;
  logic [WARPS-1:0][CNT_W-1:0] warpLen;
  logic [WARPS-1:0]            warpHit;
  logic                        anyRead, stickyValid;
  logic [WARP_W-1:0]           stickyWarp;

  wsel_datapath uData (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqWarp(enqWarp),
    .enqWrite(enqWrite), .enqRow(enqRow), .writesEqual(writesEqual), .cmd(cmd),
    .slotElig(slotElig), .slotHit(slotHit), .slotWr(slotWr), .slotWarp(slotWarp),
    .slotRow(slotRow), .warpLen(warpLen), .warpHit(warpHit), .anyRead(anyRead),
    .stickyValid(stickyValid), .stickyWarp(stickyWarp)
  );

  wsel_control uCtrl (
    .clk(clk), .rstN(rstN), .issueSlot(issueSlot), .writesEqual(writesEqual),
    .coreTol(coreTol), .kScale(kScale), .slotElig(slotElig), .slotHit(slotHit),
    .slotWr(slotWr), .slotWarp(slotWarp), .slotRow(slotRow), .warpLen(warpLen),
    .warpHit(warpHit), .anyRead(anyRead), .stickyValid(stickyValid),
    .stickyWarp(stickyWarp), .cmd(cmd), .grantValid(grantValid),
    .grantCore(grantCore), .grantWarp(grantWarp), .grantSlot(grantSlot),
    .grantRow(grantRow), .grantHit(grantHit)
  );
endmodule

// File: tb/tb_wsel_top.sv
module tb_wsel_top;
  logic       clk = 1'b0;
  logic       rstN, enqValid, enqWrite, issueSlot, writesEqual;
  logic [2:0] enqWarp;
  logic [7:0] enqRow;
  logic [15:0] coreTol;
  logic [5:0] kScale;
  logic       grantValid, grantHit;
  logic [0:0] grantCore;
  logic [2:0] grantWarp, grantSlot;
  logic [7:0] grantRow;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wsel_top dut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqWarp(enqWarp),
    .enqWrite(enqWrite), .enqRow(enqRow), .issueSlot(issueSlot),
    .writesEqual(writesEqual), .coreTol(coreTol), .kScale(kScale),
    .grantValid(grantValid), .grantCore(grantCore), .grantWarp(grantWarp),
    .grantSlot(grantSlot), .grantRow(grantRow), .grantHit(grantHit)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic doReset(int tol0, int tol1, int k, bit eq);
    @(negedge clk);
    rstN = 1'b0; enqValid = 1'b0; enqWarp = '0; enqWrite = 1'b0; enqRow = '0;
    issueSlot = 1'b0; writesEqual = eq; kScale = 6'(k);
    coreTol = {8'(tol1), 8'(tol0)};
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic enq(int w, bit wr, int row);
    @(negedge clk);
    enqValid = 1'b1; enqWarp = 3'(w); enqWrite = wr; enqRow = 8'(row);
    @(negedge clk);
    enqValid = 1'b0;
  endtask

  task automatic issue();
    @(negedge clk);
    issueSlot = 1'b1;
    @(negedge clk);
    issueSlot = 1'b0;
  endtask

  task automatic expectGrant(string req, int w, int slot, int hit);
    settle();
    check({req, " valid"}, int'(grantValid), 1);
    check({req, " warp"}, int'(grantWarp), w);
    check({req, " slot"}, int'(grantSlot), slot);
    check({req, " hit"}, int'(grantHit), hit);
  endtask

  // R1 R2 R8: reset state, invalid open row is not a hit
  task automatic testReset();
    doReset(1, 9, 4, 1'b0);
    settle();
    check("R1 no grant after reset", int'(grantValid), 0);
    check("R2 empty bank", int'(grantValid), 0);
    enq(0, 1'b0, 0);
    expectGrant("R8 row0 after reset", 0, 0, 0);
  endtask

  // R4 R3: lowest tolerance core, empty core skipped, ties to low index
  task automatic testCore();
    doReset(10, 5, 4, 1'b0);
    enq(1, 1'b0, 3);
    enq(5, 1'b0, 7);
    expectGrant("R4 lowest tol core", 5, 1, 0);
    check("R4 core index", int'(grantCore), 1);
    issue();
    expectGrant("R4 skip empty core", 1, 0, 0);
    check("R4 core0 after skip", int'(grantCore), 0);
    issue();
    settle();
    check("R3 drained", int'(grantValid), 0);
    doReset(5, 5, 4, 1'b0);
    enq(6, 1'b0, 9);
    enq(2, 1'b0, 9);
    expectGrant("R4 tol tie", 2, 1, 0);
  endtask

  // R5 R7 R3 R8: threshold weighing and sticky hit queue
  task automatic testThreshold();
    doReset(1, 9, 4, 1'b0);
    enq(3, 1'b0, 5);
    issue();
    enq(0, 1'b0, 5); enq(0, 1'b0, 5); enq(0, 1'b0, 5);
    enq(1, 1'b0, 6);
    expectGrant("R5 k=1.0 picks miss", 1, 3, 0);
    kScale = 6'd11;
    expectGrant("R5 k=2.75 picks miss", 1, 3, 0);
    kScale = 6'd12;
    expectGrant("R5 k=3.0 picks hit", 0, 0, 1);
    issue();
    kScale = 6'd0;
    expectGrant("R7 sticky after hit", 0, 1, 1);
    issue();
    expectGrant("R7 sticky second", 0, 2, 1);
    issue();
    expectGrant("R3 warp0 emptied", 1, 3, 0);
    check("R3 row of miss", int'(grantRow), 6);
    issue();
    settle();
    check("R3 none left", int'(grantValid), 0);
    enq(2, 1'b0, 6);
    expectGrant("R8 miss opened row", 2, 0, 1);
  endtask

  // R6: only hits, only misses, length ties
  task automatic testOneSided();
    doReset(1, 9, 0, 1'b0);
    enq(0, 1'b0, 2);
    issue();
    enq(2, 1'b0, 2); enq(2, 1'b0, 2);
    enq(1, 1'b0, 2); enq(1, 1'b0, 2);
    expectGrant("R6 hits only tie", 1, 2, 1);
    doReset(1, 9, 63, 1'b0);
    enq(3, 1'b0, 1);
    enq(3, 1'b0, 1);
    enq(2, 1'b0, 1);
    expectGrant("R6 misses only shortest", 2, 2, 0);
  endtask

  // R11: hit request chosen inside the warp
  task automatic testInWarp();
    doReset(1, 9, 4, 1'b0);
    enq(0, 1'b0, 4);
    issue();
    enq(0, 1'b0, 9);
    enq(0, 1'b0, 4);
    expectGrant("R11 hit slot in warp", 0, 1, 1);
    check("R11 row", int'(grantRow), 4);
  endtask

  // R9 R10: read-first versus equal treatment
  task automatic testWrites();
    doReset(1, 9, 4, 1'b0);
    enq(0, 1'b1, 1);
    enq(1, 1'b0, 2);
    enq(1, 1'b0, 2);
    expectGrant("R9 reads first", 1, 1, 0);
    writesEqual = 1'b1;
    expectGrant("R10 writes equal shortest", 0, 0, 0);
    writesEqual = 1'b0;
    settle();
    issue();
    expectGrant("R9 second read hit", 1, 2, 1);
    issue();
    expectGrant("R9 write after reads", 0, 0, 0);
  endtask

  initial begin
    rstN = 1'b0; enqValid = 1'b0; enqWarp = '0; enqWrite = 1'b0; enqRow = '0;
    issueSlot = 1'b0; writesEqual = 1'b0; coreTol = '0; kScale = '0;
    testReset();
    testCore();
    testThreshold();
    testOneSided();
    testInWarp();
    testWrites();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule